// File: doc/BRIEF.md
# Transfer Block Count Controller

This block tracks how many data blocks remain in a transfer issued by an SD host controller. Software writes one attribute word that holds a block count in its upper half and a block size in its low bits. It then starts a transfer and passes two flags with the start: whether the transfer spans several blocks, and whether the count is to be used. While a counted multi-block transfer runs, the data engine pulses a done strobe after each block. The controller lowers the live count by one on each strobe. When the count reaches zero it ends the transfer and raises a single-cycle stop request.

The attribute word cannot be written while a transfer is active. Reads always show the live remaining count, so software can inspect it while the transfer is paused between blocks. At the start of every transfer a shadow copy of the programmed count is taken. A suspend or an abort ends the transfer and puts that original value back into the count. In single-block mode the count field reads as 1, and one done strobe completes the transfer.

Top module: `blk_count_ctrl`

## Requirements
- R1: After reset the read word is all zeros, busy is low and the stop request is low.
- R2: An attribute write while idle stores bits [31:16] as the count and bits [12:0] as the block size. A read returns these fields in the same places, and bits [15:13] always read as zero.
- R3: An attribute write is ignored while busy is high, and also in the cycle in which a start is presented.
- R4: In a multi-block transfer with counting enabled, every done strobe lowers the live count by exactly one, and the read word shows the new value one cycle later.
- R5: The done strobe that takes the count from 1 to 0 clears busy. The stop request is high in the next cycle only, and the count stays at zero.
- R6: A counted multi-block start with a programmed count of 0 never sets busy. It raises the stop request for one cycle, in the cycle after the start.
- R7: After a start in single-block mode the count field reads as 1 until the next multi-block start. One done strobe ends the transfer with a stop request.
- R8: In a multi-block transfer with counting disabled, done strobes leave the count unchanged, busy stays high and no stop request is raised.
- R9: A suspend or an abort while busy clears busy without a stop request and restores the count latched at the start. It takes priority over a done strobe in the same cycle.
- R10: Done strobes while idle change nothing, and the count never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| attr_wr_i | input | 1 | Attribute word write strobe |
| attr_wdata_i | input | 32 | Attribute word write data |
| xfer_start_i | input | 1 | Start of a transfer (honoured only when idle) |
| multi_blk_i | input | 1 | Transfer spans several blocks (sampled with start) |
| cnt_en_i | input | 1 | Block counting enabled (sampled with start) |
| blk_done_i | input | 1 | One-cycle strobe from the data engine per finished block |
| abort_i | input | 1 | Abort the running transfer |
| suspend_i | input | 1 | Suspend command issued for the running transfer |
| attr_rdata_o | output | 32 | Read view of the attribute word |
| busy_o | output | 1 | A transfer is active |
| stop_req_o | output | 1 | One-cycle request to stop the data transfer |

## Verification
Directed runs cover several patterns:
- a count of three with a write arriving mid-transfer, which separates the decrement from the write lock;
- a zero count, which separates the immediate stop from a normal run;
- a single-block start, which shows the forced count of 1 against the stored value;
- an uncounted multi-block run, which shows that done strobes can be ignored;
- aborts and suspends issued after a partial run and alongside a done strobe, which separate the restore from the live count.

A long random mix of writes, starts, strobes and cancels, with small counts, then checks every cycle against a bench model. This reaches the orderings that the directed runs do not.

// File: rtl/blk_count_ctrl_pkg.sv
package blk_count_ctrl_pkg;

   typedef enum logic [1:0] {
      XF_IDLE    = 2'd0,
      XF_COUNTED = 2'd1,
      XF_FREE    = 2'd2,
      XF_SINGLE  = 2'd3
   } xfer_mode_e;

   typedef struct packed {
      logic start;
      logic multi;
      logic cnt_en;
      logic done;
      logic cancel;
   } xfer_evt_t;

endpackage

// File: rtl/bcc_size_reg.sv
module bcc_size_reg #(
   parameter int SIZE_W = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [SIZE_W-1:0] load_val_i,
   output logic [SIZE_W-1:0] size_o
);

   logic [SIZE_W-1:0] size_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         size_q <= '0;
      end else if (load_i) begin
         size_q <= load_val_i;
      end
   end

   assign size_o = size_q;

endmodule

// File: rtl/bcc_count_core.sv
module bcc_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             capture_i,
   input  logic             dec_i,
   input  logic             restore_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] shadow_o,
   output logic             is_zero_o,
   output logic             is_one_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] shadow_q;
   logic             dec_ok;

   // decrement is blocked at zero so the count cannot wrap
   assign dec_ok = dec_i && (cnt_q != '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         shadow_q <= '0;
      end else begin
         if (capture_i) begin
            shadow_q <= cnt_q;
         end
         if (restore_i) begin
            cnt_q <= shadow_q;
         end else if (dec_ok) begin
            cnt_q <= cnt_q - ONE;
         end else if (load_i) begin
            cnt_q <= load_val_i;
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign shadow_o  = shadow_q;
   assign is_zero_o = (cnt_q == '0);
   assign is_one_o  = (cnt_q == ONE);

endmodule

// File: rtl/bcc_xfer_fsm.sv
module bcc_xfer_fsm
   import blk_count_ctrl_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  xfer_evt_t evt_i,
   input  logic      cnt_zero_i,
   input  logic      cnt_one_i,
   output logic      busy_o,
   output logic      counting_o,
   output logic      capture_o,
   output logic      dec_o,
   output logic      restore_o,
   output logic      single_view_o,
   output logic      stop_o
);

   xfer_mode_e state_q, state_d;
   logic       stop_q, stop_d;
   logic       single_q;

   always_comb begin
      state_d   = state_q;
      stop_d    = 1'b0;
      capture_o = 1'b0;
      dec_o     = 1'b0;
      restore_o = 1'b0;
      unique case (state_q)
         XF_IDLE: begin
            if (evt_i.start) begin
               capture_o = 1'b1;
               if (!evt_i.multi) begin
                  state_d = XF_SINGLE;
               end else if (!evt_i.cnt_en) begin
                  state_d = XF_FREE;
               end else if (cnt_zero_i) begin
                  stop_d = 1'b1;
               end else begin
                  state_d = XF_COUNTED;
               end
            end
         end
         XF_COUNTED: begin
            if (evt_i.cancel) begin
               restore_o = 1'b1;
               state_d   = XF_IDLE;
            end else if (evt_i.done) begin
               dec_o = 1'b1;
               if (cnt_one_i) begin
                  state_d = XF_IDLE;
                  stop_d  = 1'b1;
               end
            end
         end
         XF_FREE: begin
            if (evt_i.cancel) begin
               restore_o = 1'b1;
               state_d   = XF_IDLE;
            end
         end
         XF_SINGLE: begin
            if (evt_i.cancel) begin
               restore_o = 1'b1;
               state_d   = XF_IDLE;
            end else if (evt_i.done) begin
               state_d = XF_IDLE;
               stop_d  = 1'b1;
            end
         end
         default: state_d = XF_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q  <= XF_IDLE;
         stop_q   <= 1'b0;
         single_q <= 1'b0;
      end else begin
         state_q <= state_d;
         stop_q  <= stop_d;
         if (state_q == XF_IDLE && evt_i.start) begin
            single_q <= !evt_i.multi;
         end
      end
   end

   assign busy_o        = (state_q != XF_IDLE);
   assign counting_o    = (state_q == XF_COUNTED);
   assign single_view_o = single_q;
   assign stop_o        = stop_q;

endmodule

// File: rtl/blk_count_ctrl.sv
module blk_count_ctrl
   import blk_count_ctrl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int SIZE_W = 13
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              attr_wr_i,
   input  logic [DATA_W-1:0] attr_wdata_i,
   input  logic              xfer_start_i,
   input  logic              multi_blk_i,
   input  logic              cnt_en_i,
   input  logic              blk_done_i,
   input  logic              abort_i,
   input  logic              suspend_i,
   output logic [DATA_W-1:0] attr_rdata_o,
   output logic              busy_o,
   output logic              stop_req_o
);

   localparam int CNT_LSB = DATA_W - CNT_W;
   localparam int GAP_W   = CNT_LSB - SIZE_W;

   generate
      if (CNT_W < 1 || SIZE_W < 1) begin : g_bad_widths
         $error("blk_count_ctrl: field widths must be positive");
      end
      if (GAP_W < 0) begin : g_bad_fit
         $error("blk_count_ctrl: count and size fields overlap");
      end
   endgenerate

   xfer_evt_t        evt;
   logic             busy;
   logic             counting;
   logic             capture;
   logic             dec;
   logic             restore;
   logic             single_view;
   logic             stop;
   logic             wr_ok;
   logic             cnt_zero;
   logic             cnt_one;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] shadow;
   logic [SIZE_W-1:0] size;
   logic [CNT_W-1:0] cnt_view;

   assign evt.start  = xfer_start_i;
   assign evt.multi  = multi_blk_i;
   assign evt.cnt_en = cnt_en_i;
   assign evt.done   = blk_done_i;
   assign evt.cancel = abort_i | suspend_i;

   // write lock covers the whole transfer and the start cycle itself
   assign wr_ok = attr_wr_i && !busy && !xfer_start_i;

   bcc_xfer_fsm u_fsm (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .evt_i        (evt),
      .cnt_zero_i   (cnt_zero),
      .cnt_one_i    (cnt_one),
      .busy_o       (busy),
      .counting_o   (counting),
      .capture_o    (capture),
      .dec_o        (dec),
      .restore_o    (restore),
      .single_view_o(single_view),
      .stop_o       (stop)
   );

   bcc_count_core #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (wr_ok),
      .load_val_i(attr_wdata_i[DATA_W-1:CNT_LSB]),
      .capture_i (capture),
      .dec_i     (dec),
      .restore_i (restore),
      .cnt_o     (cnt),
      .shadow_o  (shadow),
      .is_zero_o (cnt_zero),
      .is_one_o  (cnt_one)
   );

   bcc_size_reg #(.SIZE_W(SIZE_W)) u_size (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (wr_ok),
      .load_val_i(attr_wdata_i[SIZE_W-1:0]),
      .size_o    (size)
   );

   assign cnt_view = single_view ? CNT_W'(1) : cnt;

   generate
      if (GAP_W > 0) begin : g_gap
         assign attr_rdata_o = {cnt_view, {GAP_W{1'b0}}, size};
      end else begin : g_nogap
         assign attr_rdata_o = {cnt_view, size};
      end
   endgenerate

   assign busy_o     = busy;
   assign stop_req_o = stop;

endmodule

// File: rtl/blk_count_ctrl_chk.sv
module blk_count_ctrl_chk #(
   parameter int CNT_W  = 16,
   parameter int SIZE_W = 13
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              busy,
   input logic              counting,
   input logic              single_view,
   input logic              stop_req_o,
   input logic              xfer_start_i,
   input logic              attr_wr_i,
   input logic              blk_done_i,
   input logic              abort_i,
   input logic              suspend_i,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  shadow,
   input logic [SIZE_W-1:0] size,
   input logic [CNT_W-1:0]  cnt_view
);

   AST_SIZE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> $stable(size)); // R3

   AST_CNT_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && !blk_done_i && !abort_i && !suspend_i) |=> $stable(cnt)); // R3

   AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (counting && blk_done_i && !abort_i && !suspend_i) |=> (cnt == $past(cnt) - CNT_W'(1))); // R4

   AST_STOP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_req_o && !xfer_start_i) |=> !stop_req_o); // R5

   AST_STOP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_req_o |-> ($past(blk_done_i) || $past(xfer_start_i))); // R5

   AST_SINGLE_READS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      single_view |-> (cnt_view == CNT_W'(1))); // R7

   AST_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && (abort_i || suspend_i)) |=> (!busy && !stop_req_o && cnt == $past(shadow))); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy && !attr_wr_i) |=> $stable(cnt)); // R10

endmodule

bind blk_count_ctrl blk_count_ctrl_chk #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .busy        (busy),
   .counting    (counting),
   .single_view (single_view),
   .stop_req_o  (stop_req_o),
   .xfer_start_i(xfer_start_i),
   .attr_wr_i   (attr_wr_i),
   .blk_done_i  (blk_done_i),
   .abort_i     (abort_i),
   .suspend_i   (suspend_i),
   .cnt         (cnt),
   .shadow      (shadow),
   .size        (size),
   .cnt_view    (cnt_view)
);

// File: tb/blk_count_ctrl_test.sv
`timescale 1ns/1ps
module blk_count_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr, st, mu, en, dn, ab, su;
   logic [31:0] wd;
   logic [31:0] rdata;
   logic        busy, stop;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_run = 0;

   // bench model
   logic [15:0] m_cnt, m_shadow;
   logic [12:0] m_size;
   int          m_mode;   // 0 idle, 1 counted, 2 uncounted, 3 single
   bit          m_single, m_stop;

   always #10 clk = ~clk;

   blk_count_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .attr_wr_i(wr), .attr_wdata_i(wd),
      .xfer_start_i(st), .multi_blk_i(mu), .cnt_en_i(en), .blk_done_i(dn),
      .abort_i(ab), .suspend_i(su), .attr_rdata_o(rdata), .busy_o(busy),
      .stop_req_o(stop)
   );

   function automatic logic [31:0] exp_rdata();
      return {m_single ? 16'd1 : m_cnt, 3'b000, m_size};
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic chk_all(string tag);
      chk({tag, " rdata"}, rdata, exp_rdata());
      chk({tag, " busy"}, 32'(busy), 32'(m_mode != 0));
      chk({tag, " stop"}, 32'(stop), 32'(m_stop));
   endtask

   task automatic model_step();
      bit ns = 0;
      if (m_mode != 0) begin
         if (ab || su) begin
            m_cnt  = m_shadow;
            m_mode = 0;
         end else if (dn) begin
            if (m_mode == 1) begin
               m_cnt = m_cnt - 16'd1;
               if (m_cnt == 16'd0) begin m_mode = 0; ns = 1; end
            end else if (m_mode == 3) begin
               m_mode = 0; ns = 1;
            end
         end
      end else if (st) begin
         m_shadow = m_cnt;
         m_single = !mu;
         if (!mu) m_mode = 3;
         else if (!en) m_mode = 2;
         else if (m_cnt == 16'd0) ns = 1;
         else m_mode = 1;
      end else if (wr) begin
         m_cnt  = wd[31:16];
         m_size = wd[12:0];
      end
      m_stop = ns;
   endtask

   // drive at negedge, advance one clock, check at the next negedge
   task automatic cyc(string tag, bit w, logic [31:0] d, bit s, bit m, bit e,
                      bit b, bit a, bit u);
      wr = w; wd = d; st = s; mu = m; en = e; dn = b; ab = a; su = u;
      @(posedge clk);
      model_step();
      @(negedge clk);
      wr = 0; st = 0; dn = 0; ab = 0; su = 0;
      chk_all(tag);
   endtask

   task automatic idle(string tag);
      cyc(tag, 0, 32'h0, 0, 1, 1, 0, 0, 0);
   endtask

   initial begin
      #3_000_000;
      if (!done_run) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7341));
      rst_n = 0; wr = 0; wd = 0; st = 0; mu = 1; en = 1; dn = 0; ab = 0; su = 0;
      m_cnt = 0; m_shadow = 0; m_size = 0; m_mode = 0; m_single = 0; m_stop = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      chk("R1 reset rdata", rdata, 32'h0);
      chk("R1 reset busy", 32'(busy), 32'h0);
      chk("R1 reset stop", 32'(stop), 32'h0);

      // layout: junk in bits 15:13 reads back as zero
      cyc("R2 write", 1, 32'h0003_E200, 0, 1, 1, 0, 0, 0);
      chk("R2 layout", rdata, 32'h0003_0200);
      // counted run of three blocks with a write mid-run
      cyc("R4 start", 0, 32'h0, 1, 1, 1, 0, 0, 0);
      cyc("R4 first done", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      cyc("R3 write while busy", 1, 32'h0009_0001, 0, 1, 1, 0, 0, 0);
      chk("R3 count held", rdata, 32'h0002_0200);
      cyc("R4 second done", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      cyc("R5 last done", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      chk("R5 stop pulse", 32'(stop), 32'h1);
      idle("R5 stop drops");
      chk("R5 stop single cycle", 32'(stop), 32'h0);
      // idle strobes do nothing, no wrap
      cyc("R10 idle done", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      chk("R10 no wrap", rdata, 32'h0000_0200);
      // zero count start
      cyc("R6 zero start", 0, 32'h0, 1, 1, 1, 0, 0, 0);
      chk("R6 stop after zero start", 32'(stop), 32'h1);
      idle("R6 idle after");
      // write in start cycle is locked out
      cyc("R3 write with start", 1, 32'h0004_0010, 1, 0, 1, 0, 0, 0);
      chk("R7 single reads one", rdata[31:16], 32'h1);
      cyc("R7 single done", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      idle("R7 after single");
      cyc("R2 write five", 1, 32'h0005_0040, 0, 1, 1, 0, 0, 0);
      // abort with done in the same cycle restores original
      cyc("R9 start", 0, 32'h0, 1, 1, 1, 0, 0, 0);
      chk("R7 multi view back", rdata, 32'h0005_0040);
      cyc("R4 done a", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      cyc("R4 done b", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      chk("R4 live count", rdata, 32'h0003_0040);
      cyc("R9 abort with done", 0, 32'h0, 0, 1, 1, 1, 1, 0);
      chk("R9 restored", rdata, 32'h0005_0040);
      cyc("R9 start again", 0, 32'h0, 1, 1, 1, 0, 0, 0);
      cyc("R4 done c", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      cyc("R9 suspend", 0, 32'h0, 0, 1, 1, 0, 0, 1);
      chk("R9 suspend restored", rdata, 32'h0005_0040);
      // uncounted multi-block run
      cyc("R8 start", 0, 32'h0, 1, 1, 0, 0, 0, 0);
      for (int i = 0; i < 8; i++) cyc("R8 done ignored", 0, 32'h0, 0, 1, 1, 1, 0, 0);
      chk("R8 still busy", 32'(busy), 32'h1);
      cyc("R8 abort", 0, 32'h0, 0, 1, 1, 0, 1, 0);

      // constrained random mix with small counts
      for (int i = 0; i < 5000; i++) begin
         bit w = ($urandom_range(0, 9) == 0);
         bit s = ($urandom_range(0, 9) == 0);
         bit b = ($urandom_range(0, 2) == 0);
         bit a = ($urandom_range(0, 39) == 0);
         bit u = ($urandom_range(0, 39) == 0);
         bit m = ($urandom_range(0, 4) != 0);
         bit e = ($urandom_range(0, 5) != 0);
         logic [31:0] d = {16'($urandom_range(0, 5)), 16'($urandom)};
         cyc("R3/R4/R5/R7/R9/R10 random", w, d, s, m, e, b, a, u);
      end

      done_run = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule